// File: doc/BRIEF.md
# Power-Stage Fault Status Byte

This block holds one byte of fault and warning status for a power-management controller. Several bits are sticky: each records a fault or warning event from the power stage or the controller, and the bit stays set after the event has gone. One bit is a live copy of the light-load (discontinuous conduction) indication. Two bit positions are unused and always read as zero. The host reads the byte through a plain register read port. It clears chosen bits by writing ones to those positions.

Two further sources clear every supported bit at once: a one-cycle clear-faults strobe and a one-cycle output turn-on strobe. Each event input has its own disable bit. A disabled event never reaches the status byte. The block drives a summary level that feeds the alert request and the summary fields of the wider status reporting. The light-load bit is left out of that summary. No alert mask takes part in this byte.

Top module: `fault_status_reg`

## Requirements
- R1: Bit 7 of `rd_data` equals `dcm_live` as sampled at the previous clock edge. Host writes to bit 7 have no effect on it.
- R2: `summary_o` is the OR of `rd_data[6:0]`. Bit 7 never contributes to it.
- R3: The sticky bits are mapped as follows: bit 6 is set by `ctl_ot_evt`, bit 4 by `comm_err_evt` and bit 1 by `ps_ot_evt`. A bit is set in the cycle after its event is seen and then holds until it is cleared.
- R4: Bit 5 is set by any of `drv_uv_evt`, `ps_ot_evt` or `pvin_uv_evt`.
- R5: Bits 3 and 2 always read 0, including after a write of ones to them.
- R6: Bit 0 is set in every cycle in which `ps_uv_lvl` is high. When the level falls, the bit stays set until it is cleared.
- R7: A host write (`wr_en` high) clears each of bits 6, 5, 4, 1 and 0 where `wr_data` holds 1. Bits written with 0 keep their value.
- R8: A one-cycle pulse on `clr_faults` or on `out_on` clears bits 6..0.
- R9: `evt_dis` blocks events, one bit per event: [0] `ps_uv_lvl`, [1] `ps_ot_evt`, [2] `comm_err_evt`, [3] `drv_uv_evt`, [4] `pvin_uv_evt`, [5] `ctl_ot_evt`. A blocked event sets no status bit.
- R10: When a set and a clear reach the same bit in the same cycle, the bit ends up set.
- R11: While `rst_n` is low, `rd_data` and `summary_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe (write-one-to-clear) |
| wr_data | input | 8 | Host write data, a 1 clears the bit in that position |
| clr_faults | input | 1 | Global clear-faults strobe |
| out_on | input | 1 | Output turn-on strobe, clears status |
| dcm_live | input | 1 | Live discontinuous-conduction indication |
| ctl_ot_evt | input | 1 | Controller thermal shutdown event |
| drv_uv_evt | input | 1 | Gate-drive supply undervoltage event |
| ps_ot_evt | input | 1 | Power-stage thermal shutdown event |
| pvin_uv_evt | input | 1 | Power input below its fixed lockout level |
| comm_err_evt | input | 1 | Power-stage communication error event |
| ps_uv_lvl | input | 1 | Power-stage undervoltage level |
| evt_dis | input | 6 | Per-event disables, mapping given in R9 |
| rd_data | output | 8 | Status byte |
| summary_o | output | 1 | OR of bits 6..0, drives the alert request |

## Verification
The clocked properties assume that the strobes and events are sampled synchronously to `clk`. They also assume that a clear without a set, as checked after a global clear, occurs only in cycles where no enabled event is active. That is why the clear property takes the gated event vector as part of its condition. The stimulus drives every input only at the falling edge. Events and strobes are kept sparse in the random phase, so that the clear, hold and disable paths each occur on their own as well as colliding with a set.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned EVT_N  = 6;

  // event / disable indices
  localparam int unsigned EV_PS_UV  = 0;
  localparam int unsigned EV_PS_OT  = 1;
  localparam int unsigned EV_COMM   = 2;
  localparam int unsigned EV_DRV_UV = 3;
  localparam int unsigned EV_PVIN   = 4;
  localparam int unsigned EV_CTL_OT = 5;

  // status bit positions
  localparam int unsigned SB_PS_UV  = 0;
  localparam int unsigned SB_PS_OT  = 1;
  localparam int unsigned SB_COMM   = 4;
  localparam int unsigned SB_PSTAGE = 5;
  localparam int unsigned SB_CTL_OT = 6;
  localparam int unsigned SB_DCM    = 7;

  // positions that hold a clearable register
  localparam logic [STAT_W-1:0] CLEARABLE_MASK = 8'b0111_0011;
endpackage

// File: rtl/fsr_evt_gate.sv
module fsr_evt_gate #(
  parameter int unsigned N = 6
) (
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] gated_o
);
  for (genvar k = 0; k < N; k++) begin : g_gate
    assign gated_o[k] = evt_i[k] & ~dis_i[k];
  end
endmodule

// File: rtl/fsr_set_map.sv
module fsr_set_map
  import fsr_pkg::*;
(
  input  logic [EVT_N-1:0]  gated_i,
  output logic [STAT_W-1:0] set_o
);
  always_comb begin
    set_o            = '0;
    set_o[SB_CTL_OT] = gated_i[EV_CTL_OT];
    set_o[SB_PSTAGE] = gated_i[EV_DRV_UV] | gated_i[EV_PS_OT] | gated_i[EV_PVIN];
    set_o[SB_COMM]   = gated_i[EV_COMM];
    set_o[SB_PS_OT]  = gated_i[EV_PS_OT];
    set_o[SB_PS_UV]  = gated_i[EV_PS_UV];
  end
endmodule

// File: rtl/fsr_sticky_cell.sv
module fsr_sticky_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i | (q_o & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (q_en) begin
      q_o <= q_d;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> (q_o == $past(q_o))); // R3
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o); // R7
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              clr_faults,
  input  logic              out_on,
  input  logic              dcm_live,
  input  logic              ctl_ot_evt,
  input  logic              drv_uv_evt,
  input  logic              ps_ot_evt,
  input  logic              pvin_uv_evt,
  input  logic              comm_err_evt,
  input  logic              ps_uv_lvl,
  input  logic [EVT_N-1:0]  evt_dis,
  output logic [STAT_W-1:0] rd_data,
  output logic              summary_o
);
  logic [EVT_N-1:0]  evt_raw;
  logic [EVT_N-1:0]  evt_gated;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;
  logic              dcm_d;
  logic              dcm_q;
  logic              unused_wr_bits;

  always_comb begin
    evt_raw            = '0;
    evt_raw[EV_PS_UV]  = ps_uv_lvl;
    evt_raw[EV_PS_OT]  = ps_ot_evt;
    evt_raw[EV_COMM]   = comm_err_evt;
    evt_raw[EV_DRV_UV] = drv_uv_evt;
    evt_raw[EV_PVIN]   = pvin_uv_evt;
    evt_raw[EV_CTL_OT] = ctl_ot_evt;
  end

  fsr_evt_gate #(.N(EVT_N)) u_gate (
    .evt_i   (evt_raw),
    .dis_i   (evt_dis),
    .gated_o (evt_gated)
  );

  fsr_set_map u_map (
    .gated_i (evt_gated),
    .set_o   (set_vec)
  );

  always_comb begin
    clr_vec = {STAT_W{clr_faults | out_on}} | ({STAT_W{wr_en}} & wr_data);
  end

  assign unused_wr_bits = ^{wr_data[SB_DCM], wr_data[3:2]};

  for (genvar b = 0; b < STAT_W - 1; b++) begin : g_bit
    if (CLEARABLE_MASK[b]) begin : g_cell
      fsr_sticky_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[b]),
        .clr_i (clr_vec[b]),
        .q_o   (stat_q[b])
      );
    end else begin : g_zero
      assign stat_q[b] = 1'b0;
    end
  end

  // live light-load indication, one register stage
  always_comb begin
    dcm_d = dcm_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcm_q <= 1'b0;
    end else begin
      dcm_q <= dcm_d;
    end
  end

  assign stat_q[SB_DCM] = dcm_q;
  assign rd_data        = stat_q;
  assign summary_o      = |stat_q[SB_CTL_OT:0];

  AST_DCM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (rd_data[SB_DCM] == $past(dcm_live))); // R1
  AST_SUM_NO_DCM: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o |-> (rd_data[6:0] != 7'd0)); // R2
  AST_CTL_OT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ot_evt && !evt_dis[EV_CTL_OT]) |=> rd_data[SB_CTL_OT]); // R3
  AST_PVIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (pvin_uv_evt && !evt_dis[EV_PVIN]) |=> rd_data[SB_PSTAGE]); // R4
  AST_W1C_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[SB_COMM] && !(wr_en && wr_data[SB_COMM]) && !clr_faults && !out_on)
      |=> rd_data[SB_COMM]); // R7
  AST_GLOBAL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_faults || out_on) && (evt_gated == '0)) |=> (rd_data[6:0] == 7'd0)); // R8
  AST_DIS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_dis[EV_CTL_OT] && !rd_data[SB_CTL_OT]) |=> !rd_data[SB_CTL_OT]); // R9
endmodule

// File: tb/fault_status_reg_tb.sv
module fault_status_reg_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       clr_faults;
  logic       out_on;
  logic       dcm_live;
  logic       ctl_ot_evt;
  logic       drv_uv_evt;
  logic       ps_ot_evt;
  logic       pvin_uv_evt;
  logic       comm_err_evt;
  logic       ps_uv_lvl;
  logic [5:0] evt_dis;
  logic [7:0] rd_data;
  logic       summary_o;

  int unsigned n_total;
  int unsigned n_fail;
  logic [7:0]  exp_q;
  bit          done;

  fault_status_reg u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .clr_faults   (clr_faults),
    .out_on       (out_on),
    .dcm_live     (dcm_live),
    .ctl_ot_evt   (ctl_ot_evt),
    .drv_uv_evt   (drv_uv_evt),
    .ps_ot_evt    (ps_ot_evt),
    .pvin_uv_evt  (pvin_uv_evt),
    .comm_err_evt (comm_err_evt),
    .ps_uv_lvl    (ps_uv_lvl),
    .evt_dis      (evt_dis),
    .rd_data      (rd_data),
    .summary_o    (summary_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected next byte, from the requirements
  function automatic logic [7:0] model_next(input logic [7:0] cur);
    logic [7:0] set_v;
    logic [7:0] clr_v;
    logic [7:0] nxt;
    set_v    = '0;
    set_v[6] = ctl_ot_evt & ~evt_dis[5];
    set_v[5] = (drv_uv_evt & ~evt_dis[3]) | (ps_ot_evt & ~evt_dis[1]) |
               (pvin_uv_evt & ~evt_dis[4]);
    set_v[4] = comm_err_evt & ~evt_dis[2];
    set_v[1] = ps_ot_evt & ~evt_dis[1];
    set_v[0] = ps_uv_lvl & ~evt_dis[0];
    clr_v    = {8{clr_faults | out_on}} | (wr_en ? wr_data : 8'h00);
    nxt      = (set_v | (cur & ~clr_v)) & 8'b0111_0011;
    nxt[7]   = dcm_live;
    return nxt;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_data = 0; clr_faults = 0; out_on = 0;
    ctl_ot_evt = 0; drv_uv_evt = 0; ps_ot_evt = 0; pvin_uv_evt = 0;
    comm_err_evt = 0; ps_uv_lvl = 0;
  endtask

  // inputs are set at a falling edge; advance one cycle and check
  task automatic tick(input string tag);
    exp_q = model_next(exp_q);
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, exp_q);
    check({tag, " summary"}, {7'd0, summary_o}, {7'd0, |exp_q[6:0]});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    n_total = 0; n_fail = 0; done = 0;
    seed = 32'd1234;
    void'($urandom(seed));
    idle_inputs();
    dcm_live = 0; evt_dis = 0;
    rst_n = 0;
    exp_q = 0;
    ctl_ot_evt = 1; dcm_live = 1; ps_uv_lvl = 1;
    repeat (3) @(negedge clk);
    check("R11 reset byte", rd_data, 8'h00);
    check("R11 reset summary", {7'd0, summary_o}, 8'h00);
    idle_inputs(); dcm_live = 0;
    rst_n = 1;
    @(negedge clk);

    ctl_ot_evt = 1;                tick("R3 ctl_ot sets bit6");
    ctl_ot_evt = 0;                tick("R3 bit6 holds");
    wr_en = 1; wr_data = 8'h00;    tick("R7 write zero keeps");
    wr_data = 8'h40;               tick("R7 write one clears bit6");
    idle_inputs();
    drv_uv_evt = 1;                tick("R4 drv_uv sets bit5");
    idle_inputs(); wr_en = 1; wr_data = 8'h20; tick("R7 clear bit5");
    idle_inputs(); pvin_uv_evt = 1; tick("R4 pvin sets bit5");
    idle_inputs(); ps_ot_evt = 1;   tick("R3 R4 ps_ot sets bits 5 and 1");
    idle_inputs(); comm_err_evt = 1; tick("R3 comm sets bit4");
    idle_inputs(); wr_en = 1; wr_data = 8'h10; tick("R7 selective clear bit4");
    idle_inputs(); wr_en = 1; wr_data = 8'h0C; tick("R5 reserved bits stay zero");
    idle_inputs(); wr_en = 1; wr_data = 8'hFF; tick("R7 clear all");
    idle_inputs(); dcm_live = 1;   tick("R1 dcm follows, R2 no summary");
    wr_en = 1; wr_data = 8'h80;    tick("R1 write bit7 ignored");
    idle_inputs(); dcm_live = 0;   tick("R1 dcm low");
    ps_uv_lvl = 1;                 tick("R6 ps_uv sets bit0");
    wr_en = 1; wr_data = 8'h01;    tick("R6 R10 level beats write clear");
    wr_en = 0; ps_uv_lvl = 0;      tick("R6 bit0 stays after level falls");
    wr_en = 1; wr_data = 8'h01;    tick("R7 bit0 cleared");
    idle_inputs(); evt_dis = 6'h3F;
    ctl_ot_evt = 1; drv_uv_evt = 1; ps_ot_evt = 1; pvin_uv_evt = 1;
    comm_err_evt = 1; ps_uv_lvl = 1; tick("R9 all disabled");
    idle_inputs(); evt_dis = 6'h20; ctl_ot_evt = 1; comm_err_evt = 1;
    tick("R9 only ctl_ot disabled");
    idle_inputs(); evt_dis = 0; ctl_ot_evt = 1; ps_ot_evt = 1; tick("R3 set before clear");
    idle_inputs(); clr_faults = 1; tick("R8 clear-faults strobe");
    idle_inputs(); comm_err_evt = 1; tick("R3 set again");
    idle_inputs(); out_on = 1; tick("R8 turn-on strobe");
    idle_inputs(); ctl_ot_evt = 1; clr_faults = 1; tick("R10 set wins over clear");
    idle_inputs(); tick("R10 bit6 retained");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom();
      wr_en        = (r[3:0] == 4'd0);
      wr_data      = 8'($urandom());
      clr_faults   = (r[8:4] == 5'd0);
      out_on       = (r[13:9] == 5'd0);
      dcm_live     = r[14];
      ctl_ot_evt   = (r[18:15] == 4'd0);
      drv_uv_evt   = (r[22:19] == 4'd0);
      ps_ot_evt    = (r[26:23] == 4'd0);
      pvin_uv_evt  = (r[30:27] == 4'd0);
      r = $urandom();
      comm_err_evt = (r[3:0] == 4'd0);
      ps_uv_lvl    = (r[6:4] == 3'd0);
      evt_dis      = (r[9:7] == 3'd0) ? 6'(r[15:10]) : 6'h00;
      tick("R7 R8 R9 R10 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule